// File: doc/BRIEF.md
# Fractional Divider Update Controller

This block stages and applies new settings for a fractional feedback divider. The divider has three parts: an integer ratio, a fractional numerator and a modulus. A host writes shadow copies of these three values through a single-cycle register write port. It then writes a commit command. The commit captures the shadow values. On the next phase-detector tick, the captured values are moved into the active set that drives the divider.

The controller sorts each applied commit into one of two kinds. If only the numerator differs from the active set, the new value is swapped in directly, and the loop is never frozen. This lets the fraction be retuned once per phase-detector cycle. If the integer ratio or the modulus differs, the block raises a holdover request so the loop freezes its frequency. It swaps the values one tick later while still frozen, and then releases the request after a parameterised number of ticks. While that sequence runs, the block reports busy and drops further commits. Commits are also dropped whenever the alternate reference input is the selected source, because live retuning is only allowed on the primary reference.

Top module: `fdu_update_ctrl`

## Requirements
- R1: In the cycle after reset, the active set and the shadow set both hold ratio 1, numerator 0 and modulus 1. `holdover_req` and `busy` are 0, and the update bit reads 0.
- R2: A write to address 0 stores the ratio from data bits [7:0], address 1 stores the numerator from bits [23:0], and address 2 stores the modulus from bits [23:0]. Reading addresses 0 to 2 returns the shadow value zero-extended to 32 bits.
- R3: Shadow writes do not change the active outputs, even across ticks, until a commit has been applied.
- R4: A write to address 3 with data bit 0 set is a commit. After it, address 3 reads 1. On the next `pd_tick` the captured values are applied, and address 3 reads 0 from the cycle after that tick. Active outputs change only in the cycle after a tick.
- R5: When an applied commit differs from the active set only in the numerator, `act_frac` takes the new value in the cycle after the tick, and `holdover_req` stays 0.
- R6: Several commits before one tick are applied as one swap that uses the values of the last commit.
- R7: When an applied commit changes the ratio or the modulus, `holdover_req` and `busy` rise in the cycle after the applying tick, and the active outputs are still unchanged in that cycle.
- R8: In that sequence, the new ratio, numerator and modulus appear in the cycle after the next tick, while `holdover_req` is still 1. `holdover_req` and `busy` fall in the cycle after the HOLD_TICKS-th tick counted from the one that raised them (default 2).
- R9: A commit written while `busy` is 1 is dropped. The update bit stays 0, and the active set after the sequence ends is the sequence's own target.
- R10: A commit written while `ref_b_sel` is 1 is dropped. The update bit stays 0, and the active outputs do not change across a following tick.
- R11: An applied commit equal to the active set changes no output and raises no holdover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_tick | input | 1 | One-cycle pulse per phase-detector cycle |
| ref_b_sel | input | 1 | 1 when the alternate reference is the selected input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data (shadow values, update bit) |
| act_n | output | 8 | Active integer ratio |
| act_frac | output | 24 | Active fractional numerator |
| act_mod | output | 24 | Active modulus |
| holdover_req | output | 1 | Request for the loop to freeze its frequency |
| busy | output | 1 | Ratio or modulus swap sequence in progress |

## Verification
The bench runs a walk of commits that alternates fraction-only changes, ratio or modulus changes and a repeated identical commit. A design that misjudged the kind of change would either freeze the loop for a fraction tweak or swap the ratio with no holdover. It then checks the swap timing inside the holdover window. A design that swapped on the raising tick, or released after the wrong tick count, would show the new ratio with holdover low. Double commits before one tick, commits during busy and commits with the alternate reference selected are also tried. A design that queued them would apply stale or forbidden values later, or leave the update bit set.

// File: rtl/fdu_pkg.sv
package fdu_pkg;
    parameter int N_W    = 8;
    parameter int FRAC_W = 24;
    parameter int MOD_W  = 24;
    parameter int DATA_W = 32;
    parameter int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_N    = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_FRAC = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_MOD  = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] ADDR_UPD  = ADDR_W'(3);

    typedef struct packed {
        logic [N_W-1:0]    n;
        logic [FRAC_W-1:0] frac;
        logic [MOD_W-1:0]  modulus;
    } div_set_t;

    localparam div_set_t DIV_RESET = '{n: N_W'(1), frac: '0, modulus: MOD_W'(1)};

    typedef enum logic [0:0] {SEQ_IDLE, SEQ_HOLD} seq_state_e;

    // A ratio or modulus change disturbs the loop; a numerator change does not.
    function automatic logic needs_holdover(div_set_t cur, div_set_t nxt);
        return (cur.n != nxt.n) || (cur.modulus != nxt.modulus);
    endfunction
endpackage

// File: rtl/fdu_shadow_regs.sv
module fdu_shadow_regs
    import fdu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              upd_pending,
    output logic [DATA_W-1:0] rd_data,
    output div_set_t          shadow,
    output logic              commit_req
);
    div_set_t shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= DIV_RESET;
        end else if (wr_en) begin
            case (wr_addr)
                ADDR_N:    shadow_q.n       <= wr_data[N_W-1:0];
                ADDR_FRAC: shadow_q.frac    <= wr_data[FRAC_W-1:0];
                ADDR_MOD:  shadow_q.modulus <= wr_data[MOD_W-1:0];
                default:   ;
            endcase
        end
    end

    assign commit_req = wr_en && (wr_addr == ADDR_UPD) && wr_data[0];
    assign shadow     = shadow_q;

    always_comb begin
        case (rd_addr)
            ADDR_N:    rd_data = DATA_W'(shadow_q.n);
            ADDR_FRAC: rd_data = DATA_W'(shadow_q.frac);
            ADDR_MOD:  rd_data = DATA_W'(shadow_q.modulus);
            default:   rd_data = DATA_W'(upd_pending);
        endcase
    end
endmodule

// File: rtl/fdu_commit_stage.sv
module fdu_commit_stage
    import fdu_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     commit_req,
    input  logic     ref_b_sel,
    input  logic     busy,
    input  logic     apply,
    input  div_set_t shadow,
    output logic     pend_valid,
    output div_set_t staged
);
    logic     pend_q;
    div_set_t staged_q;
    logic     accept;

    assign accept = commit_req && !ref_b_sel && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q   <= 1'b0;
            staged_q <= DIV_RESET;
        end else if (accept) begin
            // a fresh commit overrides whatever was staged, so one tick applies one set
            pend_q   <= 1'b1;
            staged_q <= shadow;
        end else if (apply) begin
            pend_q   <= 1'b0;
        end
    end

    assign pend_valid = pend_q;
    assign staged     = staged_q;
endmodule

// File: rtl/fdu_swap_seq.sv
module fdu_swap_seq
    import fdu_pkg::*;
#(
    parameter int HOLD_TICKS = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     pd_tick,
    input  logic     pend_valid,
    input  div_set_t staged,
    output logic     apply,
    output div_set_t active,
    output logic     holdover,
    output logic     busy
);
    localparam int HOLD_EFF = (HOLD_TICKS < 2) ? 2 : HOLD_TICKS;
    localparam int CNT_W    = $clog2(HOLD_EFF + 1);

    seq_state_e       state_q;
    div_set_t         active_q;
    div_set_t         target_q;
    logic             hold_q;
    logic             swapped_q;
    logic [CNT_W-1:0] cnt_q;

    assign apply = (state_q == SEQ_IDLE) && pd_tick && pend_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SEQ_IDLE;
            active_q  <= DIV_RESET;
            target_q  <= DIV_RESET;
            hold_q    <= 1'b0;
            swapped_q <= 1'b0;
            cnt_q     <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (apply) begin
                        if (needs_holdover(active_q, staged)) begin
                            state_q   <= SEQ_HOLD;
                            target_q  <= staged;
                            hold_q    <= 1'b1;
                            swapped_q <= 1'b0;
                            cnt_q     <= CNT_W'(HOLD_EFF);
                        end else begin
                            active_q.frac <= staged.frac;
                        end
                    end
                end
                SEQ_HOLD: begin
                    if (pd_tick) begin
                        if (!swapped_q) begin
                            active_q  <= target_q;
                            swapped_q <= 1'b1;
                        end
                        if (cnt_q == CNT_W'(1)) begin
                            hold_q  <= 1'b0;
                            state_q <= SEQ_IDLE;
                        end
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign active   = active_q;
    assign holdover = hold_q;
    assign busy     = (state_q == SEQ_HOLD);
endmodule

// File: rtl/fdu_update_ctrl.sv
module fdu_update_ctrl
    import fdu_pkg::*;
#(
    parameter int HOLD_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pd_tick,
    input  logic              ref_b_sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [N_W-1:0]    act_n,
    output logic [FRAC_W-1:0] act_frac,
    output logic [MOD_W-1:0]  act_mod,
    output logic              holdover_req,
    output logic              busy
);
    div_set_t shadow;
    div_set_t staged;
    div_set_t active;
    logic     commit_req;
    logic     pend_valid;
    logic     apply;
    logic     seq_busy;

    fdu_shadow_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .upd_pending(pend_valid),
        .rd_data    (rd_data),
        .shadow     (shadow),
        .commit_req (commit_req)
    );

    fdu_commit_stage u_stage (
        .clk       (clk),
        .rst       (rst),
        .commit_req(commit_req),
        .ref_b_sel (ref_b_sel),
        .busy      (seq_busy),
        .apply     (apply),
        .shadow    (shadow),
        .pend_valid(pend_valid),
        .staged    (staged)
    );

    fdu_swap_seq #(.HOLD_TICKS(HOLD_TICKS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .pd_tick   (pd_tick),
        .pend_valid(pend_valid),
        .staged    (staged),
        .apply     (apply),
        .active    (active),
        .holdover  (holdover_req),
        .busy      (seq_busy)
    );

    assign busy     = seq_busy;
    assign act_n    = active.n;
    assign act_frac = active.frac;
    assign act_mod  = active.modulus;
endmodule

// File: rtl/fdu_checker.sv
module fdu_checker
    import fdu_pkg::*;
#(
    parameter int HOLD_TICKS = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              pd_tick,
    input logic [N_W-1:0]    act_n,
    input logic [FRAC_W-1:0] act_frac,
    input logic [MOD_W-1:0]  act_mod,
    input logic              holdover_req,
    input logic              busy
);
    localparam int HOLD_EFF = (HOLD_TICKS < 2) ? 2 : HOLD_TICKS;
    localparam int CNT_W    = $clog2(HOLD_EFF + 2);

    logic [CNT_W-1:0] hold_ticks;

    always_ff @(posedge clk) begin
        if (rst || !holdover_req) hold_ticks <= '0;
        else if (pd_tick && hold_ticks != {CNT_W{1'b1}}) hold_ticks <= hold_ticks + CNT_W'(1);
    end

    assert_reset_defaults_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (act_n == N_W'(1) && act_frac == '0 && act_mod == MOD_W'(1)
                        && !holdover_req && !busy));

    assert_swap_after_tick_R4: assert property (@(posedge clk) disable iff (rst)
        (act_n != $past(act_n) || act_frac != $past(act_frac) || act_mod != $past(act_mod))
        |-> $past(pd_tick));

    assert_frac_no_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (act_frac != $past(act_frac) && act_n == $past(act_n) && act_mod == $past(act_mod))
        |-> (!holdover_req && !$past(holdover_req)));

    assert_hold_edge_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(holdover_req) || $fell(holdover_req)) |-> $past(pd_tick));

    assert_major_in_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (act_n != $past(act_n) || act_mod != $past(act_mod))
        |-> (holdover_req && $past(holdover_req)));

    assert_hold_length_R8: assert property (@(posedge clk) disable iff (rst)
        hold_ticks <= CNT_W'(HOLD_EFF));
endmodule

bind fdu_update_ctrl fdu_checker #(.HOLD_TICKS(HOLD_TICKS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pd_tick     (pd_tick),
    .act_n       (act_n),
    .act_frac    (act_frac),
    .act_mod     (act_mod),
    .holdover_req(holdover_req),
    .busy        (busy)
);

// File: tb/test_fdu_update_ctrl.sv
`timescale 1ns/1ps
module test_fdu_update_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pd_tick = 1'b0;
    logic        ref_b_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [7:0]  act_n;
    logic [23:0] act_frac;
    logic [23:0] act_mod;
    logic        holdover_req;
    logic        busy;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    fdu_update_ctrl i_fdu_update_ctrl (
        .clk(clk), .rst(rst), .pd_tick(pd_tick), .ref_b_sel(ref_b_sel),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .act_n(act_n), .act_frac(act_frac), .act_mod(act_mod),
        .holdover_req(holdover_req), .busy(busy)
    );

    // vector: {ratio[55:48], modulus[47:24], numerator[23:0]}
    localparam int NV = 6;
    localparam logic [55:0] VEC [NV] = '{
        {8'd1,  24'd1000, 24'd5},
        {8'd1,  24'd1000, 24'd7},
        {8'd20, 24'd1000, 24'd7},
        {8'd20, 24'd1000, 24'd999},
        {8'd20, 24'd1000, 24'd999},
        {8'd33, 24'd5000, 24'd4999}
    };

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic tick();
        @(negedge clk);
        pd_tick = 1'b1;
        @(negedge clk);
        pd_tick = 1'b0;
    endtask

    task automatic chk_active(string req, logic [7:0] n, logic [23:0] m, logic [23:0] f);
        chk(req, "act_n", 32'(act_n), 32'(n));
        chk(req, "act_mod", 32'(act_mod), 32'(m));
        chk(req, "act_frac", 32'(act_frac), 32'(f));
    endtask

    task automatic load(logic [7:0] n, logic [23:0] m, logic [23:0] f);
        wr(2'd0, 32'(n));
        wr(2'd2, 32'(m));
        wr(2'd1, 32'(f));
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [7:0]  mn;
        logic [23:0] mm, mf;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk_active("R1", 8'd1, 24'd1, 24'd0);
        chk("R1", "holdover_req", 32'(holdover_req), 32'd0);
        chk("R1", "busy", 32'(busy), 32'd0);
        rd(2'd0, d); chk("R1", "shadow n", d, 32'd1);
        rd(2'd2, d); chk("R1", "shadow mod", d, 32'd1);
        rd(2'd3, d); chk("R1", "update bit", d, 32'd0);

        // R2 field widths and read-back; R3 no effect before commit
        wr(2'd0, 32'hFFFF_FFAB);
        wr(2'd1, 32'hDEAD_BEEF);
        wr(2'd2, 32'h1234_5678);
        rd(2'd0, d); chk("R2", "shadow n", d, 32'h0000_00AB);
        rd(2'd1, d); chk("R2", "shadow frac", d, 32'h00AD_BEEF);
        rd(2'd2, d); chk("R2", "shadow mod", d, 32'h0034_5678);
        tick(); tick();
        chk_active("R3", 8'd1, 24'd1, 24'd0);

        // vector walk: R4/R5/R7/R8/R11
        mn = 8'd1; mm = 24'd1; mf = 24'd0;
        for (int i = 0; i < NV; i++) begin
            logic [7:0]  vn;
            logic [23:0] vm, vf;
            logic        major;
            vn = VEC[i][55:48]; vm = VEC[i][47:24]; vf = VEC[i][23:0];
            major = (vn != mn) || (vm != mm);
            load(vn, vm, vf);
            wr(2'd3, 32'd1);
            rd(2'd3, d); chk("R4", "update bit after commit", d, 32'd1);
            tick();
            rd(2'd3, d); chk("R4", "update bit self-clear", d, 32'd0);
            if (major) begin
                chk("R7", "holdover rise", 32'(holdover_req), 32'd1);
                chk("R7", "busy rise", 32'(busy), 32'd1);
                chk_active("R7", mn, mm, mf);
                tick();
                chk_active("R8", vn, vm, vf);
                chk("R8", "holdover during swap", 32'(holdover_req), 32'd1);
                tick();
                chk("R8", "holdover release", 32'(holdover_req), 32'd0);
                chk("R8", "busy release", 32'(busy), 32'd0);
            end else begin
                chk_active((vf == mf) ? "R11" : "R5", vn, vm, vf);
                chk((vf == mf) ? "R11" : "R5", "holdover", 32'(holdover_req), 32'd0);
            end
            mn = vn; mm = vm; mf = vf;
        end

        // R6 two commits, one tick
        wr(2'd1, 32'd100); wr(2'd3, 32'd1);
        wr(2'd1, 32'd200); wr(2'd3, 32'd1);
        tick();
        chk_active("R6", mn, mm, 24'd200);
        chk("R6", "holdover", 32'(holdover_req), 32'd0);
        tick();
        chk_active("R6", mn, mm, 24'd200);
        mf = 24'd200;

        // R9 commit during busy is dropped
        load(8'd50, mm, 24'd300);
        wr(2'd3, 32'd1);
        tick();
        chk("R9", "busy", 32'(busy), 32'd1);
        wr(2'd1, 32'd777);
        wr(2'd3, 32'd1);
        rd(2'd3, d); chk("R9", "update bit while busy", d, 32'd0);
        tick(); tick();
        chk("R9", "busy cleared", 32'(busy), 32'd0);
        tick(); tick();
        chk_active("R9", 8'd50, mm, 24'd300);
        mn = 8'd50; mf = 24'd300;

        // R10 alternate reference blocks commit
        ref_b_sel = 1'b1;
        wr(2'd0, 32'd9);
        wr(2'd1, 32'd55);
        wr(2'd3, 32'd1);
        rd(2'd3, d); chk("R10", "update bit", d, 32'd0);
        tick();
        chk_active("R10", mn, mm, mf);
        chk("R10", "holdover", 32'(holdover_req), 32'd0);
        ref_b_sel = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule